// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for software that has stopped making progress. A down-counter runs on the system clock while the watchdog is on. If software does not restart it in time, the counter runs out. The block then asks for a system reset. In two-stage mode it first raises an interrupt, which gives software one more full period to recover, and it asks for a reset only if that interrupt is still pending at the next time-out.

Software reaches the block through a small word-addressed register port with three locations. A control register holds the enable, the lock bit, the response mode and a power-of-two period select. A restart location reloads the counter, but only when a fixed key value is written to it. An acknowledge location clears the interrupt. A newly selected period does not affect the count already running. The lock bit keeps the watchdog on once it has been armed, and only a system reset releases it. The `MIN_EXP` parameter sets the shortest period as an exponent, with a default of 16.

Top module: `wdog_two_stage`

## Requirements
- R1: The control register at byte offset 0x00 reads back the enable in bit 0, the response mode in bit 1, the lock in bit 3 and the period select in bits 7:4. Bit 2 and bits 31:8 always read 0, and writing 1 to them has no effect. All other offsets read 0.
- R2: A period select of n sets the time-out period to 2^(MIN_EXP+n) enabled clock cycles, counted from the reload to the time-out event.
- R3: Writing a new period select leaves the running count unchanged. The new period is first used by the next restart or the next time-out reload.
- R4: The lock bit (bit 3) can only be set by a write. Writing 0 to it leaves it at 1, and only the system reset clears it.
- R5: While both the lock and the enable are 1, a control write with bit 0 at 0 leaves the enable at 1. The other fields are still written.
- R6: While the enable is 0, the count holds its value, no reset request is issued and the interrupt output is low. When the watchdog is enabled again, the time-out arrives after the remaining count.
- R7: With response mode 0, a time-out gives a reset request that is high for exactly one cycle, and the interrupt stays low.
- R8: With response mode 1, the first time-out sets the interrupt. If the interrupt is still pending at the next time-out, a one-cycle reset request follows.
- R9: Writing 0x1ACCE551 to byte offset 0x04 reloads the counter from the current period select. Any other value written there has no effect.
- R10: Writing a value with bit 0 set to byte offset 0x08 clears a pending interrupt. After this, the next time-out raises the interrupt again and does not give a reset.
- R11: After a system reset, the control register reads 0, both outputs are low, and the counter holds the shortest period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| irq_o | output | 1 | First-stage time-out interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The main check is the number of cycles to the time-out, measured over six period selects in both response modes. An error in the shift base, an off-by-one in the reload, or a swapped order of the two response modes would each give a different cycle count or a different output. Further stimulus changes the period while the counter runs, pauses the counter with the enable, and writes a wrong restart key before the right one. These tests separate a count that is only reloaded at the allowed moments from one that picks up new values at other times. The lock test writes all ones and then all zeros. It shows whether the reserved bits are masked and whether the lock and the enable stick, and a second system reset shows that the lock is released.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

   localparam int unsigned SEL_W   = 4;
   localparam int unsigned NUM_SEL = 1 << SEL_W;
   localparam int unsigned BUS_W   = 32;

   localparam logic [BUS_W-1:0] KICK_KEY = 32'h1ACC_E551;

   localparam int unsigned OFF_CTRL = 0;
   localparam int unsigned OFF_KICK = 4;
   localparam int unsigned OFF_ACK  = 8;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             frz;
      logic             rsp;
      logic             en;
   } ctrl_t;

endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
   import wdt2_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output ctrl_t             ctrl_o,
   output logic              kick_o,
   output logic              ack_o
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFF_KICK);
   localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);
   localparam int unsigned       PAD_W  = BUS_W - SEL_W - 4;

   ctrl_t ctrl_q;
   logic  wr_ctrl;
   logic  wr_kick;
   logic  wr_ack;

   assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
   assign wr_kick = bus_sel && bus_wr && (bus_addr == A_KICK);
   assign wr_ack  = bus_sel && bus_wr && (bus_addr == A_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.sel <= bus_wdata[SEL_W+3:4];
         ctrl_q.rsp <= bus_wdata[1];
         ctrl_q.frz <= ctrl_q.frz | bus_wdata[3];
         ctrl_q.en  <= (ctrl_q.frz && ctrl_q.en) ? 1'b1 : bus_wdata[0];
      end
   end

   assign kick_o = wr_kick && (bus_wdata == KICK_KEY);
   assign ack_o  = wr_ack && bus_wdata[0];
   assign ctrl_o = ctrl_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata = {{PAD_W{1'b0}}, ctrl_q.sel, ctrl_q.frz, 1'b0, ctrl_q.rsp, ctrl_q.en};
      end
   end

   assert_frz_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.frz |=> ctrl_q.frz);

   assert_locked_en_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.frz && ctrl_q.en) |=> ctrl_q.en);

   assert_ctrl_hold_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter
   import wdt2_pkg::*;
#(
   parameter int unsigned MIN_EXP = 16,
   parameter int unsigned CNT_W   = MIN_EXP + NUM_SEL
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             kick_i,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] INIT_CNT = CNT_W'(1) << MIN_EXP;

   logic [CNT_W-1:0] period_tab [NUM_SEL];
   logic [CNT_W-1:0] cnt_q;

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_period
      assign period_tab[i] = CNT_W'(1) << (MIN_EXP + i);
   end

   assign expire_o = en_i && (cnt_q == CNT_W'(1)) && !kick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= INIT_CNT;
      end else if (kick_i || expire_o) begin
         cnt_q <= period_tab[sel_i];
      end else if (en_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assert_cnt_nonzero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);

   assert_hold_when_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !kick_i) |=> $stable(cnt_q));

   assert_kick_reload_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> $onehot(cnt_q));

endmodule

// File: rtl/wdt2_response.sv
module wdt2_response (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic rsp_i,
   input  logic expire_i,
   input  logic ack_i,
   output logic irq_o,
   output logic rst_req_o
);

   logic irq_q;
   logic rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         rst_q <= expire_i && (!rsp_i || irq_q);
         if (expire_i && rsp_i && !irq_q) begin
            irq_q <= 1'b1;
         end else if (ack_i) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign irq_o     = irq_q && en_i;
   assign rst_req_o = rst_q;

   assert_rst_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);

   assert_no_rst_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !rst_q);

   assert_second_stage_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q && $past(rsp_i)) |-> $past(irq_q));

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdt2_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned MIN_EXP = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              rst_req_o
);

   localparam int unsigned CNT_W = MIN_EXP + NUM_SEL;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4 to reach every register");
   end
   if (MIN_EXP < 1 || MIN_EXP > 40) begin : g_bad_exp
      $error("MIN_EXP must lie in 1..40");
   end

   ctrl_t ctrl;
   logic  kick;
   logic  ack;
   logic  expire;

   wdt2_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ctrl_o    (ctrl),
      .kick_o    (kick),
      .ack_o     (ack)
   );

   wdt2_counter #(.MIN_EXP(MIN_EXP), .CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ctrl.en),
      .sel_i    (ctrl.sel),
      .kick_i   (kick),
      .expire_o (expire)
   );

   wdt2_response u_response (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ctrl.en),
      .rsp_i     (ctrl.rsp),
      .expire_i  (expire),
      .ack_i     (ack),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   assert_out_reset_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && !rst_req_o));

endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;

   localparam int MIN_EXP = 4;
   localparam int NV      = 6;
   localparam logic [31:0] KEY = 32'h1ACC_E551;

   localparam int V_SEL [NV] = '{0, 1, 2, 3, 5, 7};
   localparam int V_RSP [NV] = '{0, 1, 0, 1, 1, 0};
   localparam int V_EXP [NV] = '{16, 32, 64, 128, 512, 2048};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        rst_req_o;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   wdog_two_stage #(.ADDR_W(4), .MIN_EXP(MIN_EXP)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input int sel, input int rsp, input int en);
      return {24'b0, 4'(sel), 1'b0, 1'b0, 1'(rsp), 1'(en)};
   endfunction

   task automatic wait_out(input bit want_rst, input int limit, output int n);
      n = 0;
      do begin
         @(posedge clk);
         #1;
         n++;
      end while (!(want_rst ? rst_req_o : irq_o) && n < limit);
   endtask

   task automatic park(input int sel);
      bus_write(4'h0, ctrl_word(sel, 0, 0));
      bus_write(4'h4, KEY);
      bus_write(4'h8, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         total++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int n;
      int sum;

      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
      // R11: reset state
      bus_read(4'h0, rd);
      chk("R11 ctrl after reset", int'(rd), 0);
      chk("R11 irq after reset", int'(irq_o), 0);
      chk("R11 rst_req after reset", int'(rst_req_o), 0);

      // R11: counter holds the shortest period after reset
      bus_write(4'h0, ctrl_word(0, 0, 1));
      wait_out(1'b1, 5000, n);
      chk("R11 first period after reset", n, 16);
      park(0);

      // Table walk: R2, R7, R8
      for (int i = 0; i < NV; i++) begin
         park(V_SEL[i]);
         bus_write(4'h0, ctrl_word(V_SEL[i], V_RSP[i], 1));
         if (V_RSP[i] == 0) begin
            wait_out(1'b1, 5000, n);
            chk("R2 period mode0", n, V_EXP[i]);
            chk("R7 no irq in mode0", int'(irq_o), 0);
            @(posedge clk); #1;
            chk("R7 reset pulse one cycle", int'(rst_req_o), 0);
         end else begin
            wait_out(1'b0, 5000, n);
            chk("R2 period mode1", n, V_EXP[i]);
            chk("R8 first stage no reset", int'(rst_req_o), 0);
            wait_out(1'b1, 5000, n);
            chk("R8 second stage reset", n, V_EXP[i]);
            @(posedge clk); #1;
            chk("R8 reset pulse one cycle", int'(rst_req_o), 0);
         end
      end
      park(0);

      // R3: a new select does not touch the running count
      bus_write(4'h0, ctrl_word(0, 0, 1));
      repeat (4) @(posedge clk);
      bus_write(4'h0, ctrl_word(3, 0, 1));
      wait_out(1'b1, 5000, n);
      chk("R3 running count kept", n, 11);
      wait_out(1'b1, 5000, n);
      chk("R3 new period after time-out", n, 128);
      park(0);

      // R6: disabled counter holds
      bus_write(4'h0, ctrl_word(0, 0, 1));
      repeat (4) @(posedge clk);
      bus_write(4'h0, ctrl_word(0, 0, 0));
      sum = 0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk); #1;
         sum += int'(rst_req_o) + int'(irq_o);
      end
      chk("R6 no output while disabled", sum, 0);
      bus_write(4'h0, ctrl_word(0, 0, 1));
      wait_out(1'b1, 5000, n);
      chk("R6 remaining count after re-enable", n, 11);
      park(0);

      // R9: wrong key ignored, right key reloads
      bus_write(4'h0, ctrl_word(0, 0, 1));
      repeat (3) @(posedge clk);
      bus_write(4'h4, 32'h1ACC_E550);
      wait_out(1'b1, 5000, n);
      chk("R9 wrong key ignored", n, 12);
      repeat (5) @(posedge clk);
      bus_write(4'h0, ctrl_word(2, 0, 1));
      bus_write(4'h4, KEY);
      wait_out(1'b1, 5000, n);
      chk("R9 key reload uses current select", n, 64);
      park(0);

      // R10: acknowledge clears the interrupt, next time-out is an irq again
      park(1);
      bus_write(4'h0, ctrl_word(1, 1, 1));
      wait_out(1'b0, 5000, n);
      chk("R10 irq raised", n, 32);
      bus_write(4'h8, 32'h1);
      chk("R10 irq cleared", int'(irq_o), 0);
      sum = 0;
      n = 0;
      while (!irq_o && n < 5000) begin
         @(posedge clk); #1;
         n++;
         sum += int'(rst_req_o);
      end
      chk("R10 irq again after clear", n, 31);
      chk("R10 no reset after clear", sum, 0);
      park(0);

      // R1, R4, R5: reserved bits, lock and enable
      bus_write(4'h0, 32'hFFFF_FFFF);
      bus_read(4'h0, rd);
      chk("R1 reserved bits read zero", int'(rd), 32'hFB);
      bus_read(4'h4, rd);
      chk("R1 other offset reads zero", int'(rd), 0);
      bus_write(4'h0, 32'h0);
      bus_read(4'h0, rd);
      chk("R4 R5 lock and enable stick", int'(rd), 32'h09);

      // R4: only system reset releases the lock
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      bus_read(4'h0, rd);
      chk("R4 lock cleared by reset", int'(rd), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule